// File: doc/BRIEF.md
# Embedded-controller link message engine

This block frames whole messages on top of a byte-level I2C target port. For every bus byte event the port reports four status flags: interrupt, end of transfer, address received and read-not-write. It also passes in the byte that was received. The engine answers each event, one clock later, with the byte to put on the bus when the master is reading. It also pulses an error flag for any status combination that is out of place.

Inbound messages from the master are collected in a local buffer. Their length is checked against the length the header bytes announce, and a good message is offered on a valid/ready port with its length and a random-access read port. Outbound traffic works as follows. Software writes one message into a transmit buffer and marks it ready, and the engine pulls an active-low request line to ask the master for a read. When the master writes command 0x01 and then reads with a repeated start, the engine streams the message out. If nothing is queued, it streams a three-byte no-op instead. A read cut short is replayed from the first byte. A complete inbound reply that is not an event marks the outbound message as answered and frees the transmit buffer.

Top module: `ec_link_engine`

## Requirements
- R1: After reset `req_n` is 1, `rx_valid`, `tx_valid`, `err_pulse`, `ovf_pulse` and `ob_busy` are 0.
- R2: Only an event with irq=1, addr=1, rnw=0, end=0 starts a transfer, whatever the current state, and moves the engine to the command state. If `ev_byte` differs from `own_addr` then `err_pulse` is raised, but the command state is still entered. An event with irq=0 raises `err_pulse` and changes nothing else. Any other non-start event in idle raises `err_pulse`.
- R3: In the command state, an event with irq=1 and the other three flags 0 stores `ev_byte` as message byte 0 and moves to the first-data state. Any other event raises `err_pulse` and returns to idle. The same happens when the previous inbound message is still held on `rx_valid`.
- R4: In the first-data state, a plain write byte becomes message byte 1 and the engine enters the receive state. There each further plain write byte is stored at the next position.
- R5: The expected inbound length is found from byte 0 (b0) and byte 1 (b1). When b0[7]=0 or b0[6:5]=2 it is b1+2. When b0[6:5]=0 it is 2, and when it is 1 it is 3. When it is 3, no length is valid.
- R6: An end event with rnw=0 in the receive state completes the message. If the byte count equals the expected length, `rx_valid` rises with `rx_len` equal to that count, and it holds until `rx_ready` is sampled high. Otherwise `err_pulse` is raised and the message is dropped.
- R7: A write byte received while RX_DEPTH bytes are already stored is discarded and pulses `ovf_pulse`. A message that overflowed is dropped with `err_pulse` at its end.
- R8: A repeated-start read (irq, addr, rnw set, end clear) in the first-data state is accepted only when byte 0 is 0x01. When it is accepted, the first outbound byte is sent and the engine enters the transmit state. Otherwise `err_pulse` is raised, 0xFF is sent and the engine goes idle.
- R9: In the transmit state, each read event (irq=1, rnw=1, addr=0, end=0) sends the next outbound byte on `tx_valid`/`tx_byte` one clock later. A read past the last byte sends 0xFF, raises `err_pulse` and returns to idle. A write-direction or address event there also raises `err_pulse` and returns to idle.
- R10: An end event in the transmit state before all bytes were sent rewinds to byte 0 and drives `req_n` low again. After all bytes were sent, it returns to idle.
- R11: A read entered with no outbound message pending sends the bytes 0x02, 0x07, 0x02.
- R12: `req_n` falls when `ob_send` is accepted, and `ob_send` is accepted only while `ob_busy` is 0. It rises when a repeated-start read event arrives.
- R13: `ob_busy` falls only when a complete inbound message with b0[7]=0 is accepted. An accepted event message leaves it unchanged.
- R14: An event with both end and rnw set produces no `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 8 | Address byte expected at transfer start |
| ev_valid | input | 1 | One byte event this cycle |
| ev_irq | input | 1 | Status: interrupt flag |
| ev_end | input | 1 | Status: end of transfer |
| ev_addr | input | 1 | Status: address byte received |
| ev_rnw | input | 1 | Status: master is reading |
| ev_byte | input | 8 | Byte received with the event |
| tx_valid | output | 1 | A byte must be handed to the bus |
| tx_byte | output | 8 | Byte to transmit |
| err_pulse | output | 1 | Protocol error seen on the last event |
| ovf_pulse | output | 1 | Inbound byte discarded, buffer full |
| req_n | output | 1 | Active-low read request to the master |
| ob_wr_en | input | 1 | Write one outbound buffer byte |
| ob_wr_idx | input | clog2(TX_DEPTH) | Outbound buffer index |
| ob_wr_data | input | 8 | Outbound buffer data |
| ob_send | input | 1 | Mark the outbound message ready |
| ob_len | input | clog2(TX_DEPTH+1) | Outbound message length in bytes |
| ob_busy | output | 1 | Outbound message pending an answer |
| rx_valid | output | 1 | Inbound message available |
| rx_ready | input | 1 | Inbound message consumed |
| rx_len | output | clog2(RX_DEPTH+1) | Inbound message length |
| rx_rd_idx | input | clog2(RX_DEPTH) | Inbound buffer read index |
| rx_rd_data | output | 8 | Inbound buffer byte at the index |

## Verification
The stimulus first covers well-formed writes of each length class: non-event, fixed two and three byte events, and a variable event. This shows whether the length decoder picks the right rule for each header form. A mismatched class and an overrun message then show whether the drop path is separate from the accept path. Outbound traffic is run three ways: a full read, a read cut short and replayed, and a read with nothing queued. These show the replay rewind and the no-op source apart from the normal stream. Misplaced status combinations in each state, a wrong address and a read after the wrong command show which error paths recover to idle and which still go on.

// File: rtl/ec_link_pkg.sv
`timescale 1ns/1ps
package ec_link_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CMD   = 3'd1,
      ST_FIRST = 3'd2,
      ST_TX    = 3'd3,
      ST_RECV  = 3'd4
   } link_state_e;

   localparam logic [7:0] READ_CMD  = 8'h01;
   localparam logic [7:0] NOOP_EDGE = 8'h02;
   localparam logic [7:0] NOOP_MID  = 8'h07;
   localparam int         NOOP_LEN  = 3;

   // expected inbound length from the two header bytes
   function automatic logic [8:0] expected_len(input logic [7:0] b0, input logic [7:0] b1);
      logic [8:0] n;
      if (!b0[7] || b0[6:5] == 2'd2) n = {1'b0, b1} + 9'd2;
      else if (b0[6:5] == 2'd0)      n = 9'd2;
      else if (b0[6:5] == 2'd1)      n = 9'd3;
      else                           n = 9'd0;
      return n;
   endfunction

endpackage

// File: rtl/ec_rx_frame.sv
`timescale 1ns/1ps
module ec_rx_frame #(
   parameter int DEPTH = 32,
   localparam int PW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          push_i,
   input  logic          finish_i,
   input  logic [7:0]    byte_i,
   input  logic          ready_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic [7:0]    rd_data_o,
   output logic [7:0]    cmd_o,
   output logic          len_ok_o,
   output logic          event_o,
   output logic          ovf_o,
   output logic          valid_o,
   output logic [PW-1:0] len_o
);
   import ec_link_pkg::*;

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] pos_q;
   logic          ovf_q;
   logic          valid_q;
   logic          full;

   assign full = (pos_q == PW'(DEPTH));

   always_ff @(posedge clk) begin
      if (start_i)
         mem[0] <= byte_i;
      else if (push_i && !full)
         mem[pos_q[IW-1:0]] <= byte_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         ovf_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (start_i) begin
            pos_q <= PW'(1);
            ovf_q <= 1'b0;
         end else if (push_i) begin
            if (full) ovf_q <= 1'b1;
            else      pos_q <= pos_q + 1'b1;
         end
         if (finish_i && len_ok_o)
            valid_q <= 1'b1;
         else if (valid_q && ready_i)
            valid_q <= 1'b0;
      end
   end

   assign cmd_o     = mem[0];
   assign event_o   = mem[0][7];
   assign len_ok_o  = !ovf_q && (9'(pos_q) == expected_len(mem[0], mem[1]));
   assign ovf_o     = push_i && full;
   assign valid_o   = valid_q;
   assign len_o     = pos_q;
   assign rd_data_o = mem[rd_idx_i];

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !start_i) |=> (pos_q == $past(pos_q)));

   p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready_i) |=> (valid_q && $stable(pos_q)));

endmodule

// File: rtl/ec_tx_source.sv
`timescale 1ns/1ps
module ec_tx_source #(
   parameter int DEPTH = 32,
   localparam int PW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [7:0]    wr_data_i,
   input  logic          send_i,
   input  logic [PW-1:0] send_len_i,
   input  logic          begin_i,
   input  logic          next_i,
   input  logic          rewind_i,
   input  logic          answer_i,
   input  logic          release_i,
   output logic [7:0]    first_o,
   output logic [7:0]    cur_o,
   output logic          more_o,
   output logic          done_o,
   output logic          pending_o,
   output logic          req_n_o
);
   import ec_link_pkg::*;

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] len_q;
   logic [PW-1:0] pos_q;
   logic          pend_q;
   logic          noop_q;
   logic          req_n_q;
   logic          accept;
   logic          set_low;
   logic [PW-1:0] cur_len;
   logic [7:0]    noop_byte;

   assign accept  = send_i && !pend_q;
   assign set_low = accept || rewind_i;

   always_ff @(posedge clk) begin
      if (wr_en_i && !pend_q) mem[wr_idx_i] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         pos_q   <= '0;
         pend_q  <= 1'b0;
         noop_q  <= 1'b0;
         req_n_q <= 1'b1;
      end else begin
         if (accept) begin
            pend_q <= 1'b1;
            len_q  <= send_len_i;
         end else if (answer_i) begin
            pend_q <= 1'b0;
         end
         if (begin_i) begin
            noop_q <= !pend_q;
            pos_q  <= PW'(1);
         end else if (rewind_i) begin
            pos_q  <= '0;
         end else if (next_i) begin
            pos_q  <= pos_q + 1'b1;
         end
         if (set_low)        req_n_q <= 1'b0;
         else if (release_i) req_n_q <= 1'b1;
      end
   end

   assign noop_byte = (pos_q == PW'(1)) ? NOOP_MID : NOOP_EDGE;
   assign cur_len   = noop_q ? PW'(NOOP_LEN) : len_q;
   assign cur_o     = noop_q ? noop_byte : mem[pos_q[IW-1:0]];
   assign first_o   = pend_q ? mem[0] : NOOP_EDGE;
   assign more_o    = pos_q < cur_len;
   assign done_o    = pos_q == cur_len;
   assign pending_o = pend_q;
   assign req_n_o   = req_n_q;

   p_req_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !set_low) |=> req_n_q);

   p_answer_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(answer_i));

endmodule

// File: rtl/ec_link_engine.sv
`timescale 1ns/1ps
module ec_link_engine #(
   parameter int RX_DEPTH = 32,
   parameter int TX_DEPTH = 32,
   localparam int RX_PW = $clog2(RX_DEPTH + 1),
   localparam int RX_IW = $clog2(RX_DEPTH),
   localparam int TX_PW = $clog2(TX_DEPTH + 1),
   localparam int TX_IW = $clog2(TX_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       own_addr,
   input  logic             ev_valid,
   input  logic             ev_irq,
   input  logic             ev_end,
   input  logic             ev_addr,
   input  logic             ev_rnw,
   input  logic [7:0]       ev_byte,
   output logic             tx_valid,
   output logic [7:0]       tx_byte,
   output logic             err_pulse,
   output logic             ovf_pulse,
   output logic             req_n,
   input  logic             ob_wr_en,
   input  logic [TX_IW-1:0] ob_wr_idx,
   input  logic [7:0]       ob_wr_data,
   input  logic             ob_send,
   input  logic [TX_PW-1:0] ob_len,
   output logic             ob_busy,
   output logic             rx_valid,
   input  logic             rx_ready,
   output logic [RX_PW-1:0] rx_len,
   input  logic [RX_IW-1:0] rx_rd_idx,
   output logic [7:0]       rx_rd_data
);
   import ec_link_pkg::*;

   generate
      if (RX_DEPTH < 4 || RX_DEPTH > 255) begin : g_bad_rx
         $error("RX_DEPTH must lie in 4..255");
      end
      if (TX_DEPTH < 4 || TX_DEPTH > 255) begin : g_bad_tx
         $error("TX_DEPTH must lie in 4..255");
      end
   endgenerate

   link_state_e state_q, nxt, cur;
   logic        is_start, is_rdstart, is_plain, live;
   logic        rx_start, rx_push, rx_fin, rx_ok, rx_event, rx_ovf;
   logic [7:0]  rx_cmd;
   logic        tx_begin, tx_next, tx_rew, tx_more, tx_done, tx_answer, tx_release;
   logic [7:0]  tx_first, tx_cur, snd;
   logic        err_d;

   assign live       = ev_valid && ev_irq;
   assign is_start   = ev_addr && !ev_rnw && !ev_end;
   assign is_rdstart = ev_addr && ev_rnw && !ev_end;
   assign is_plain   = !ev_addr && !ev_rnw && !ev_end;
   assign tx_answer  = rx_fin && rx_ok && !rx_event;
   assign tx_release = live && is_rdstart;

   always_comb begin
      nxt      = state_q;
      cur      = state_q;
      snd      = 8'hFF;
      err_d    = 1'b0;
      rx_start = 1'b0;
      rx_push  = 1'b0;
      rx_fin   = 1'b0;
      tx_begin = 1'b0;
      tx_next  = 1'b0;
      tx_rew   = 1'b0;
      if (ev_valid && !ev_irq) begin
         err_d = 1'b1;
      end else if (live) begin
         if (is_start) cur = ST_IDLE;
         case (cur)
            ST_IDLE: begin
               if (!is_start) err_d = 1'b1;
            end
            ST_CMD: begin
               if (!is_plain || rx_valid) begin
                  err_d = 1'b1;
                  nxt   = ST_IDLE;
               end else begin
                  rx_start = 1'b1;
                  nxt      = ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (is_rdstart) begin
                  if (rx_cmd != READ_CMD) begin
                     err_d = 1'b1;
                     nxt   = ST_IDLE;
                  end else begin
                     tx_begin = 1'b1;
                     snd      = tx_first;
                     nxt      = ST_TX;
                  end
               end else if (is_plain) begin
                  rx_push = 1'b1;
                  nxt     = ST_RECV;
               end else begin
                  err_d = 1'b1;
                  nxt   = ST_IDLE;
               end
            end
            ST_TX: begin
               if (ev_end) begin
                  if (!tx_done) tx_rew = 1'b1;
                  else          nxt    = ST_IDLE;
               end else if (!ev_rnw || ev_addr) begin
                  err_d = 1'b1;
                  nxt   = ST_IDLE;
               end else if (tx_more) begin
                  snd     = tx_cur;
                  tx_next = 1'b1;
               end else begin
                  err_d = 1'b1;
                  nxt   = ST_IDLE;
               end
            end
            ST_RECV: begin
               if (ev_end && !ev_rnw) begin
                  rx_fin = 1'b1;
                  nxt    = ST_IDLE;
                  if (!rx_ok) err_d = 1'b1;
               end else if (ev_rnw || ev_addr) begin
                  err_d = 1'b1;
                  nxt   = ST_IDLE;
               end else begin
                  rx_push = 1'b1;
               end
            end
            default: nxt = ST_IDLE;
         endcase
         if (is_start) begin
            nxt = ST_CMD;
            if (ev_byte != own_addr) err_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tx_valid  <= 1'b0;
         tx_byte   <= 8'hFF;
         err_pulse <= 1'b0;
         ovf_pulse <= 1'b0;
      end else begin
         state_q   <= nxt;
         tx_valid  <= live && ev_rnw && !ev_end;
         tx_byte   <= snd;
         err_pulse <= err_d;
         ovf_pulse <= rx_ovf;
      end
   end

   ec_rx_frame #(.DEPTH(RX_DEPTH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (rx_start),
      .push_i    (rx_push),
      .finish_i  (rx_fin),
      .byte_i    (ev_byte),
      .ready_i   (rx_ready),
      .rd_idx_i  (rx_rd_idx),
      .rd_data_o (rx_rd_data),
      .cmd_o     (rx_cmd),
      .len_ok_o  (rx_ok),
      .event_o   (rx_event),
      .ovf_o     (rx_ovf),
      .valid_o   (rx_valid),
      .len_o     (rx_len)
   );

   ec_tx_source #(.DEPTH(TX_DEPTH)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (ob_wr_en),
      .wr_idx_i   (ob_wr_idx),
      .wr_data_i  (ob_wr_data),
      .send_i     (ob_send),
      .send_len_i (ob_len),
      .begin_i    (tx_begin),
      .next_i     (tx_next),
      .rewind_i   (tx_rew),
      .answer_i   (tx_answer),
      .release_i  (tx_release),
      .first_o    (tx_first),
      .cur_o      (tx_cur),
      .more_o     (tx_more),
      .done_o     (tx_done),
      .pending_o  (ob_busy),
      .req_n_o    (req_n)
   );

   p_cmd_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMD && $past(state_q) != ST_CMD) |->
         $past(ev_valid && ev_irq && ev_addr && !ev_rnw && !ev_end));

   p_tx_read_only_r14: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(ev_valid && ev_irq && ev_rnw && !ev_end));

endmodule

// File: tb/ec_link_engine_tb.sv
`timescale 1ns/1ps
module ec_link_engine_tb;
   localparam int DEPTH = 32;
   localparam logic [7:0] OWN = 8'h8A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       ev_valid = 0, ev_irq = 0, ev_end = 0, ev_addr = 0, ev_rnw = 0;
   logic [7:0] ev_byte = 0;
   logic       tx_valid, err_pulse, ovf_pulse, req_n, ob_busy, rx_valid;
   logic [7:0] tx_byte, rx_rd_data;
   logic       ob_wr_en = 0, ob_send = 0, rx_ready = 0;
   logic [4:0] ob_wr_idx = 0, rx_rd_idx = 0;
   logic [7:0] ob_wr_data = 0;
   logic [5:0] ob_len = 0, rx_len;

   ec_link_engine u_dut (
      .clk(clk), .rst_n(rst_n), .own_addr(OWN),
      .ev_valid(ev_valid), .ev_irq(ev_irq), .ev_end(ev_end), .ev_addr(ev_addr),
      .ev_rnw(ev_rnw), .ev_byte(ev_byte),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .err_pulse(err_pulse),
      .ovf_pulse(ovf_pulse), .req_n(req_n),
      .ob_wr_en(ob_wr_en), .ob_wr_idx(ob_wr_idx), .ob_wr_data(ob_wr_data),
      .ob_send(ob_send), .ob_len(ob_len), .ob_busy(ob_busy),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len),
      .rx_rd_idx(rx_rd_idx), .rx_rd_data(rx_rd_data)
   );

   int checks = 0, errors = 0;
   string cur_req = "R1";

   // behavioural reference state
   int         m_state = 0;
   logic [7:0] rxq[$];
   logic [7:0] held[$];
   logic [7:0] txq[$];
   bit m_ovf = 0, m_rxv = 0, m_pend = 0, m_noop = 0, m_req = 1;
   int m_pos = 0;
   bit e_tv = 0, e_err = 0, e_ovf = 0;
   logic [7:0] e_tb = 8'hFF;

   task automatic cmp(input string sig, input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL [%s] %s (%s): got %0h expected %0h", cur_req, sig, tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      cmp("tx_valid", "R9", tx_valid, e_tv);
      if (e_tv) cmp("tx_byte", "R9", tx_byte, e_tb);
      cmp("err_pulse", "R2", err_pulse, e_err);
      cmp("ovf_pulse", "R7", ovf_pulse, e_ovf);
      cmp("req_n", "R12", req_n, m_req);
      cmp("rx_valid", "R6", rx_valid, m_rxv);
      if (m_rxv) cmp("rx_len", "R6", rx_len, held.size());
      cmp("ob_busy", "R13", ob_busy, m_pend);
      e_tv = 0; e_err = 0; e_ovf = 0; e_tb = 8'hFF;
      ev_valid = 0; ob_wr_en = 0; ob_send = 0; rx_ready = 0;
   endtask

   function automatic int exp_len(input logic [7:0] b0, input logic [7:0] b1);
      if (b0[7] == 0 || b0[6:5] == 2) return b1 + 2;
      if (b0[6:5] == 0) return 2;
      if (b0[6:5] == 1) return 3;
      return 0;
   endfunction

   function automatic logic [7:0] out_at(input int p);
      if (m_noop) return (p == 1) ? 8'h07 : 8'h02;
      return txq[p];
   endfunction

   task automatic model(input bit irq, input bit e, input bit a, input bit r, input logic [7:0] b);
      bit st, rds, pw;
      int s, len;
      logic [7:0] send = 8'hFF;
      if (!irq) begin e_err = 1; return; end
      st = a && !r && !e; rds = a && r && !e; pw = !a && !r && !e;
      s = st ? 0 : m_state;
      case (s)
         0: if (!st) e_err = 1;
         1: if (!pw || m_rxv) begin e_err = 1; m_state = 0; end
            else begin rxq = {b}; m_ovf = 0; m_state = 2; end
         2: if (rds) begin
               if (rxq[0] != 8'h01) begin e_err = 1; m_state = 0; end
               else begin m_noop = !m_pend; m_pos = 1; send = m_noop ? 8'h02 : txq[0]; m_state = 3; end
            end else if (pw) begin rxq.push_back(b); m_state = 4; end
            else begin e_err = 1; m_state = 0; end
         3: begin
               len = m_noop ? 3 : txq.size();
               if (e) begin
                  if (m_pos != len) begin m_pos = 0; m_req = 0; end
                  else m_state = 0;
               end else if (!r || a) begin e_err = 1; m_state = 0; end
               else if (m_pos < len) begin send = out_at(m_pos); m_pos++; end
               else begin e_err = 1; m_state = 0; end
            end
         4: if (e && !r) begin
               m_state = 0;
               if (!m_ovf && rxq.size() == exp_len(rxq[0], rxq[1])) begin
                  m_rxv = 1; held = rxq;
                  if (rxq[0][7] == 0) m_pend = 0;
               end else e_err = 1;
            end else if (r || a) begin e_err = 1; m_state = 0; end
            else if (rxq.size() < DEPTH) rxq.push_back(b);
            else begin m_ovf = 1; e_ovf = 1; end
         default: m_state = 0;
      endcase
      if (st) begin m_state = 1; if (b != OWN) e_err = 1; end
      if (r && !e) begin e_tv = 1; e_tb = send; end
      if (rds) m_req = 1;
   endtask

   task automatic ev(input bit irq, input bit e, input bit a, input bit r, input logic [7:0] b);
      ev_valid = 1; ev_irq = irq; ev_end = e; ev_addr = a; ev_rnw = r; ev_byte = b;
      model(irq, e, a, r, b);
      tick();
   endtask

   task automatic st_w(input logic [7:0] a); ev(1, 0, 1, 0, a); endtask
   task automatic wb(input logic [7:0] b);   ev(1, 0, 0, 0, b); endtask
   task automatic rd_start();                ev(1, 0, 1, 1, 8'h00); endtask
   task automatic rd();                      ev(1, 0, 0, 1, 8'h00); endtask
   task automatic end_w();                   ev(1, 1, 0, 0, 8'h00); endtask
   task automatic end_r();                   ev(1, 1, 0, 1, 8'h00); endtask

   task automatic wmsg(input logic [7:0] q[$]);
      st_w(OWN);
      foreach (q[i]) wb(q[i]);
      end_w();
   endtask

   task automatic load(input logic [7:0] q[$]);
      foreach (q[i]) begin
         ob_wr_en = 1; ob_wr_idx = 5'(i); ob_wr_data = q[i];
         tick();
      end
      ob_send = 1; ob_len = 6'(q.size());
      if (!m_pend) begin txq = q; m_pend = 1; m_req = 0; end
      tick();
   endtask

   task automatic accept();
      rx_ready = 1; m_rxv = 0;
      tick();
   endtask

   // R4: stored message bytes read back through the read port
   task automatic chk_rx();
      foreach (held[i]) begin
         rx_rd_idx = 5'(i);
         #1;
         cmp("rx_rd_data", "R4", rx_rd_data, held[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL [watchdog] run did not finish: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      cur_req = "R1"; tick();

      cur_req = "R2"; ev(0, 0, 1, 0, OWN);          // irq clear: error only
      wb(8'h33);                                    // plain byte in idle

      cur_req = "R12"; load('{8'h03, 8'h44, 8'h55, 8'h66});
      cur_req = "R8"; st_w(OWN); wb(8'h01); rd_start();
      cur_req = "R9"; rd(); rd(); rd();
      cur_req = "R14"; end_r();
      cur_req = "R13"; wmsg('{8'h01, 8'h02, 8'hAA, 8'hBB});
      chk_rx(); accept();

      cur_req = "R10"; load('{8'h03, 8'hA1, 8'hA2});
      st_w(OWN); wb(8'h01); rd_start(); rd(); end_r();
      st_w(OWN); wb(8'h01); rd_start(); rd(); rd(); end_r();
      wmsg('{8'h01, 8'h00}); accept();

      cur_req = "R11"; st_w(OWN); wb(8'h01); rd_start(); rd(); rd();
      rd(); end_r();                                 // underflow read then end

      cur_req = "R8"; st_w(OWN); wb(8'h05); rd_start();

      cur_req = "R5"; wmsg('{8'h85, 8'h10}); chk_rx(); accept();
      wmsg('{8'hA3, 8'h01, 8'h02}); chk_rx(); accept();
      wmsg('{8'hC0, 8'h01, 8'h09}); chk_rx(); accept();
      wmsg('{8'hA0, 8'h01});                        // class 1 with two bytes
      wmsg('{8'hE0, 8'h01});                        // class 3 never valid
      wmsg('{8'h21, 8'h03, 8'h0A});                 // short non-event

      cur_req = "R13"; load('{8'h02, 8'h09});
      wmsg('{8'h81, 8'h77}); accept();              // event keeps pending

      cur_req = "R2"; st_w(8'h20); wb(8'h81); wb(8'h5A); end_w(); chk_rx();
      cur_req = "R6"; st_w(OWN); wb(8'h81);         // blocked while held
      repeat (2) tick();
      accept();

      cur_req = "R3"; st_w(OWN); rd(); wb(8'h33);
      st_w(OWN); end_w();

      cur_req = "R7";
      begin
         logic [7:0] q[$];
         q = '{8'h10, 8'd30};
         for (int i = 0; i < 32; i++) q.push_back(8'(i + 8'h40));
         wmsg(q);
      end
      wmsg('{8'h10, 8'd1, 8'hEE}); chk_rx(); accept();

      cur_req = "R4";
      begin
         logic [7:0] q[$];
         q = '{8'h30, 8'd30};
         for (int i = 0; i < 30; i++) q.push_back(8'(i * 7));
         wmsg(q); chk_rx(); accept();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule